// File: doc/BRIEF.md
# Interrupt Request Arbitration Core

This block arbitrates among eight interrupt lines for a single processor. It watches the request pins for rising edges, drops any edge that arrives on a masked line, and records the rest as pending. Each newly recorded request can produce a one-cycle pulse on the interrupt output toward the processor. A service already in progress on the same line or on any higher-numbered line suppresses that pulse.

When the processor acknowledges, the core picks the highest-numbered pending line and clears its pending bit. It then either marks the line as in service or, in automatic end-of-interrupt mode, finishes it at once. The core returns an 8-bit vector formed from the supplied base and the line number. If the cascade map says a secondary controller sits on that line, the core raises a flag so that the secondary controller supplies the vector instead. An end-of-interrupt strobe names a line and retires its in-service bit. If anything is still pending, the request check runs again for the highest pending line.

The mask, vector base, cascade map and automatic end-of-interrupt flag come from a separate command sequencer. The pending and in-service vectors are exported for that sequencer to read back.

Top module: `irq_arbiter_core`

## Requirements
- R1: A pending bit is recorded only on a low-to-high change of its pin, one cycle after the clock edge at which the pin is first seen high. A pin held high records no further request until it has been seen low.
- R2: An edge on a line whose `mask` bit is 1 is discarded. Clearing the mask afterwards does not bring the request back.
- R3: When a new request is recorded, `int_pulse` is 1 for exactly the following cycle, but only if no in-service bit at that line's index or at any higher index is set.
- R4: When `ack` is seen, the highest-numbered set bit of `irr_out` is chosen and cleared.
- R5: With `auto_eoi` at 0, an acknowledge sets the chosen line's bit in `isr_out`. With `auto_eoi` at 1, that bit is left clear and the line gets end-of-interrupt treatment at once (R8).
- R6: In the cycle after an acknowledge, `vec_valid` is 1 and `vec_out` equals `vec_base` ORed with the 3-bit line number in bits 2:0.
- R7: If the chosen line's bit is set in `cascade_map`, `slave_vec` is 1 and `vec_out` is 0 in the cycle after the acknowledge. Otherwise `slave_vec` is 0.
- R8: `eoi_valid` clears the `isr_out` bit selected by `eoi_line`. If any pending bit then remains, `int_pulse` is 1 in the next cycle unless an in-service bit at or above the highest pending line is still set.
- R9: An acknowledge with `irr_out` at zero returns `vec_base` ORed with 7, clears `slave_vec`, and leaves `irr_out` and `isr_out` unchanged.
- R10: With `rst` high, `irr_out`, `isr_out`, `int_pulse`, `vec_valid` and the stored previous pin levels are cleared. A pin already high when reset is released therefore records a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pins | input | 8 | Interrupt request pins, one per line |
| mask | input | 8 | Per-line mask, 1 discards edges |
| vec_base | input | 8 | Vector base, line number is ORed into bits 2:0 |
| cascade_map | input | 8 | Lines that carry a secondary controller |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| ack | input | 1 | Acknowledge strobe from the processor |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 3 | Line retired by the end-of-interrupt |
| int_pulse | output | 1 | One-cycle interrupt request to the processor |
| vec_valid | output | 1 | Vector result valid, one cycle after ack |
| vec_out | output | 8 | Returned vector |
| slave_vec | output | 1 | Secondary controller must supply the vector |
| irr_out | output | 8 | Pending register |
| isr_out | output | 8 | In-service register |

## Verification
A wrong pending or in-service bit is visible on `irr_out` and `isr_out` in the cycle after the edge, acknowledge or end-of-interrupt that caused it. A wrong choice of line shows up in the low bits of `vec_out` one cycle after `ack`. A wrong blocking decision shows up as a missing or extra `int_pulse` in that same cycle. A stale previous-pin level shows only at the next pin transition, so the bench holds pins high across acknowledges and across reset to expose it.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int DEF_LINES = 8;
  localparam int DEF_VEC_W = 8;

  typedef enum logic [1:0] {
    ACK_NONE  = 2'd0,
    ACK_LINE  = 2'd1,
    ACK_SPUR  = 2'd2
  } ack_kind_t;
endpackage

// File: rtl/irq_edge_gate.sv
`timescale 1ns/1ps
module irq_edge_gate #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins,
  input  logic [N-1:0] mask,
  output logic [N-1:0] new_req
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pins;
  end

  // rising edge on an unmasked line
  assign new_req = pins & ~prev_q & ~mask;
endmodule

// File: rtl/irq_top_finder.sv
`timescale 1ns/1ps
module irq_top_finder #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [LW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        idx = LW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pend_state.sv
`timescale 1ns/1ps
module irq_pend_state #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  new_req,
  input  logic [N-1:0]  mask,
  input  logic          ack,
  input  logic          auto_eoi,
  input  logic          sel_any,
  input  logic [LW-1:0] sel_idx,
  input  logic          eoi_valid,
  input  logic [LW-1:0] eoi_line,
  output logic [N-1:0]  irr_q,
  output logic [N-1:0]  isr_q,
  output logic [N-1:0]  irr_nx,
  output logic [N-1:0]  isr_nx
);
  logic [N-1:0] clr_irr, set_isr, clr_isr;

  always_comb begin
    clr_irr = '0;
    set_isr = '0;
    clr_isr = '0;
    if (ack && sel_any) begin
      clr_irr[sel_idx] = 1'b1;
      if (auto_eoi) clr_isr[sel_idx] = 1'b1;
      else          set_isr[sel_idx] = 1'b1;
    end
    if (eoi_valid) clr_isr[eoi_line] = 1'b1;
    irr_nx = (irr_q & ~clr_irr) | new_req;
    isr_nx = (isr_q | set_isr) & ~clr_isr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irr_nx;
      isr_q <= isr_nx;
    end
  end

  // R1
  irr_rise_from_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ((irr_q & ~$past(irr_q)) & ~$past(new_req)) == '0);

  // R2
  masked_never_latched_chk: assert property (@(posedge clk) disable iff (rst)
    ((irr_q & ~$past(irr_q)) & $past(mask)) == '0);

  // R5
  isr_set_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ((isr_q & ~$past(isr_q)) != '0) |-> ($past(ack) && !$past(auto_eoi)));

  // R8
  eoi_clears_bit_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |=> !isr_q[$past(eoi_line)]);
endmodule

// File: rtl/irq_arbiter_core.sv
`timescale 1ns/1ps
module irq_arbiter_core
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = DEF_LINES,
  parameter int VEC_W     = DEF_VEC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_pins,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [VEC_W-1:0]     vec_base,
  input  logic [NUM_LINES-1:0] cascade_map,
  input  logic                 auto_eoi,
  input  logic                 ack,
  input  logic                 eoi_valid,
  input  logic [$clog2(NUM_LINES)-1:0] eoi_line,
  output logic                 int_pulse,
  output logic                 vec_valid,
  output logic [VEC_W-1:0]     vec_out,
  output logic                 slave_vec,
  output logic [NUM_LINES-1:0] irr_out,
  output logic [NUM_LINES-1:0] isr_out
);
  localparam int LW = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] new_req, irr_q, isr_q, irr_nx, isr_nx, fresh_ok;
  logic [LW-1:0]        sel_idx, re_idx;
  logic                 sel_any, re_any, re_blocked, recheck_en, pulse_d;
  ack_kind_t            ack_kind;
  logic [VEC_W-1:0]     vec_d;
  logic                 slave_d;

  irq_edge_gate #(.N(NUM_LINES)) u_edge (
    .clk(clk), .rst(rst), .pins(irq_pins), .mask(mask), .new_req(new_req)
  );

  irq_top_finder #(.N(NUM_LINES), .LW(LW)) u_sel (
    .vec(irr_q), .idx(sel_idx), .any(sel_any)
  );

  irq_pend_state #(.N(NUM_LINES), .LW(LW)) u_state (
    .clk(clk), .rst(rst), .new_req(new_req), .mask(mask),
    .ack(ack), .auto_eoi(auto_eoi), .sel_any(sel_any), .sel_idx(sel_idx),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line),
    .irr_q(irr_q), .isr_q(isr_q), .irr_nx(irr_nx), .isr_nx(isr_nx)
  );

  irq_top_finder #(.N(NUM_LINES), .LW(LW)) u_recheck (
    .vec(irr_nx), .idx(re_idx), .any(re_any)
  );

  // new request passes if nothing in service at or above its line
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_fresh
    assign fresh_ok[g] = new_req[g] & ~(|isr_q[NUM_LINES-1:g]);
  end

  always_comb begin
    re_blocked = 1'b0;
    for (int i = 0; i < NUM_LINES; i++)
      if (i >= int'(re_idx) && isr_nx[i]) re_blocked = 1'b1;
  end

  assign recheck_en = eoi_valid | (ack & auto_eoi & sel_any);
  assign pulse_d    = (|fresh_ok) | (recheck_en & re_any & ~re_blocked);

  always_comb begin
    ack_kind = ACK_NONE;
    if (ack) ack_kind = sel_any ? ACK_LINE : ACK_SPUR;
    vec_d   = vec_base | {{(VEC_W-LW){1'b0}}, {LW{1'b1}}};
    slave_d = 1'b0;
    if (ack_kind == ACK_LINE) begin
      if (cascade_map[sel_idx]) begin
        slave_d = 1'b1;
        vec_d   = '0;
      end else begin
        vec_d = vec_base | {{(VEC_W-LW){1'b0}}, sel_idx};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_pulse <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      slave_vec <= 1'b0;
    end else begin
      int_pulse <= pulse_d;
      vec_valid <= (ack_kind != ACK_NONE);
      if (ack_kind != ACK_NONE) begin
        vec_out   <= vec_d;
        slave_vec <= slave_d;
      end
    end
  end

  assign irr_out = irr_q;
  assign isr_out = isr_q;

  // R9
  spurious_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irr_out == '0 && !eoi_valid) |=>
      (vec_valid && !slave_vec && vec_out[LW-1:0] == {LW{1'b1}} && isr_out == $past(isr_out)));

  // R7
  slave_zero_vec_chk: assert property (@(posedge clk) disable iff (rst)
    slave_vec |-> (vec_out == '0));

  // R4
  ack_clears_top_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irr_out != '0) |=> ($countones(irr_out & ~$past(new_req)) < $countones($past(irr_out))));
endmodule

// File: tb/irq_arbiter_core_test.sv
`timescale 1ns/1ps
module irq_arbiter_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_pins = '0, mask = '0, vec_base = 8'h20, cascade_map = '0;
  logic       auto_eoi = 1'b0, ack = 1'b0, eoi_valid = 1'b0;
  logic [2:0] eoi_line = '0;
  logic       int_pulse, vec_valid, slave_vec;
  logic [7:0] vec_out, irr_out, isr_out;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_arbiter_core uut (
    .clk(clk), .rst(rst), .irq_pins(irq_pins), .mask(mask), .vec_base(vec_base),
    .cascade_map(cascade_map), .auto_eoi(auto_eoi), .ack(ack),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line), .int_pulse(int_pulse),
    .vec_valid(vec_valid), .vec_out(vec_out), .slave_vec(slave_vec),
    .irr_out(irr_out), .isr_out(isr_out)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_eoi(logic [2:0] ln);
    eoi_valid = 1'b1; eoi_line = ln; step(); eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "irr", irr_out, 8'h00);
    chk("R10", "isr", isr_out, 8'h00);
    chk("R10", "pulse", {7'd0, int_pulse}, 8'h00);
    chk("R10", "vvalid", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic t_basic();
    irq_pins[3] = 1'b1; step();
    chk("R1", "irr after edge", irr_out, 8'h08);
    chk("R3", "pulse", {7'd0, int_pulse}, 8'h01);
    step();
    chk("R3", "pulse one cycle", {7'd0, int_pulse}, 8'h00);
    do_ack();
    chk("R6", "vvalid", {7'd0, vec_valid}, 8'h01);
    chk("R6", "vector", vec_out, 8'h23);
    chk("R5", "isr set", isr_out, 8'h08);
    chk("R4", "irr cleared", irr_out, 8'h00);
    chk("R7", "no slave", {7'd0, slave_vec}, 8'h00);
    step();
    chk("R6", "vvalid drops", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic t_level_and_eoi();
    step(); step();
    chk("R1", "held pin no request", irr_out, 8'h00);
    irq_pins[3] = 1'b0; step();
    irq_pins[3] = 1'b1; step();
    chk("R1", "re-edge", irr_out, 8'h08);
    chk("R3", "blocked by own isr", {7'd0, int_pulse}, 8'h00);
    irq_pins[3] = 1'b0;
    do_eoi(3'd3);
    chk("R8", "isr cleared", isr_out, 8'h00);
    chk("R8", "re-request pulse", {7'd0, int_pulse}, 8'h01);
    do_ack();
    chk("R5", "isr", isr_out, 8'h08);
    do_eoi(3'd3);
    chk("R8", "isr empty", isr_out, 8'h00);
    chk("R8", "no pulse when none pending", {7'd0, int_pulse}, 8'h00);
  endtask

  task automatic t_mask();
    mask = 8'h20; irq_pins[5] = 1'b1; step();
    chk("R2", "masked irr", irr_out, 8'h00);
    chk("R2", "masked pulse", {7'd0, int_pulse}, 8'h00);
    irq_pins[5] = 1'b0; mask = 8'h00; step(); step();
    chk("R2", "not revived", irr_out, 8'h00);
  endtask

  task automatic t_priority();
    irq_pins = 8'h44; step();
    chk("R1", "two edges", irr_out, 8'h44);
    chk("R3", "pulse", {7'd0, int_pulse}, 8'h01);
    irq_pins = 8'h00;
    do_ack();
    chk("R4", "highest first", vec_out, 8'h26);
    chk("R4", "irr left", irr_out, 8'h04);
    chk("R5", "isr", isr_out, 8'h40);
    irq_pins[7] = 1'b1; step();
    chk("R3", "higher passes", {7'd0, int_pulse}, 8'h01);
    irq_pins[4] = 1'b1; step();
    chk("R3", "lower blocked", {7'd0, int_pulse}, 8'h00);
    chk("R1", "irr", irr_out, 8'h94);
    irq_pins = 8'h00;
    do_ack();
    chk("R4", "line 7", vec_out, 8'h27);
    chk("R5", "isr two", isr_out, 8'hC0);
    do_eoi(3'd7);
    chk("R8", "still blocked by 6", {7'd0, int_pulse}, 8'h00);
    chk("R8", "isr", isr_out, 8'h40);
    do_eoi(3'd6);
    chk("R8", "now unblocked", {7'd0, int_pulse}, 8'h01);
    do_ack();
    chk("R4", "line 4", vec_out, 8'h24);
    do_eoi(3'd4);
    do_ack();
    chk("R4", "line 2", vec_out, 8'h22);
    do_eoi(3'd2);
    chk("R8", "drained", irr_out | isr_out, 8'h00);
  endtask

  task automatic t_auto();
    auto_eoi = 1'b1; irq_pins = 8'h41; step();
    chk("R1", "irr", irr_out, 8'h41);
    irq_pins = 8'h00;
    do_ack();
    chk("R5", "auto keeps isr clear", isr_out, 8'h00);
    chk("R6", "vector", vec_out, 8'h26);
    chk("R8", "auto re-request", {7'd0, int_pulse}, 8'h01);
    do_ack();
    chk("R6", "vector 0", vec_out, 8'h20);
    chk("R8", "no re-request when empty", {7'd0, int_pulse}, 8'h00);
    chk("R4", "irr empty", irr_out, 8'h00);
    auto_eoi = 1'b0;
  endtask

  task automatic t_cascade();
    cascade_map = 8'h02; irq_pins[1] = 1'b1; step();
    irq_pins[1] = 1'b0;
    do_ack();
    chk("R7", "slave flag", {7'd0, slave_vec}, 8'h01);
    chk("R7", "vector zero", vec_out, 8'h00);
    chk("R5", "isr", isr_out, 8'h02);
    do_eoi(3'd1);
    cascade_map = 8'h00;
  endtask

  task automatic t_spurious();
    do_ack();
    chk("R9", "vector", vec_out, 8'h27);
    chk("R9", "valid", {7'd0, vec_valid}, 8'h01);
    chk("R9", "state", irr_out | isr_out, 8'h00);
    irq_pins[2] = 1'b1; step(); irq_pins[2] = 1'b0;
    do_ack();
    chk("R5", "isr", isr_out, 8'h04);
    do_ack();
    chk("R9", "vector with isr", vec_out, 8'h27);
    chk("R9", "isr unchanged", isr_out, 8'h04);
    chk("R9", "slave clear", {7'd0, slave_vec}, 8'h00);
    do_eoi(3'd2);
  endtask

  task automatic t_reset_mid();
    irq_pins[5] = 1'b1; step();
    chk("R1", "irr", irr_out, 8'h20);
    rst = 1'b1; step();
    chk("R10", "irr cleared", irr_out, 8'h00);
    chk("R10", "pulse cleared", {7'd0, int_pulse}, 8'h00);
    rst = 1'b0; step();
    chk("R10", "held pin after reset", irr_out, 8'h20);
    chk("R10", "pulse after reset", {7'd0, int_pulse}, 8'h01);
    irq_pins = 8'h00;
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    t_reset();
    t_basic();
    t_level_and_eoi();
    t_mask();
    t_priority();
    t_auto();
    t_cascade();
    t_spurious();
    t_reset_mid();
    step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule